// File: doc/BRIEF.md
# Multi-select byte-wide static RAM

This block is a 128-word by 8-bit memory with a microprocessor-style bus interface. A 7-bit word address selects a location. Two active-low strobes request a read or a write. Five chip selects of mixed polarity gate the whole device. Two of the selects are active high and three are active low. The device responds only when all five are at their active levels. A single select at its inactive level leaves the bus undriven, whatever the strobes say.

The bidirectional data bus is split into a data-in byte, a registered data-out byte and an output-enable. A pad ring outside the block builds the tri-state driver from these signals. Everything runs on one clock. A write commits on the rising edge on which the write condition holds. A read presents the addressed byte, together with the output-enable, one cycle after the edge that samples the address and the read condition.

The storage is arranged as 16 rows of 8 bytes. The upper four address bits pick the row, and the lower three bits pick the byte within that row.

Top module: `mram_top`

## Requirements
- R1: The block stores 128 independent 8-bit words, addressed by `addr_i[6:0]`; writing one word leaves every other word unchanged.
- R2: The device is selected only when `sel_hi_i == 2'b11` and `sel_lo_i == 3'b000` at the same sampling edge.
- R3: When any one select bit is at its inactive level on an edge, `dout_oe_o` is 0 in the following cycle and no word is written on that edge, whatever `rd_n_i` and `wr_n_i` are.
- R4: When the device is selected and `rd_n_i == 0` and `wr_n_i == 1` on an edge, `dout_oe_o` is 1 in the following cycle and `dout_o` holds the word stored at the sampled address.
- R5: When the device is selected and `wr_n_i == 0` on an edge, `din_i` is stored at the sampled address on that edge, and `dout_oe_o` is 0 in the following cycle whatever the level of `rd_n_i`.
- R6: When the device is selected with both strobes high (standby), `dout_oe_o` is 0 in the following cycle and the stored contents are kept.
- R7: Whenever `dout_oe_o` is 0, `dout_o` is 8'h00.
- R8: Read data follows the address one cycle later. During back-to-back reads with a new address on every edge, each cycle shows the word for the address sampled on the previous edge.
- R9: While `rst_n_i` is low, and in the first cycle after reset, `dout_oe_o` is 0 and `dout_o` is 8'h00.
- R10: A read issued on the edge right after a write to the same address returns the newly written byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; all state changes on its rising edge |
| rst_n_i | input | 1 | Asynchronous active-low reset of the output stage |
| addr_i | input | 7 | Word address |
| rd_n_i | input | 1 | Read strobe, active low |
| wr_n_i | input | 1 | Write strobe, active low |
| sel_hi_i | input | 2 | Chip selects that are active high |
| sel_lo_i | input | 3 | Chip selects that are active low |
| din_i | input | 8 | Byte taken from the bus on a write |
| dout_o | output | 8 | Registered read byte; zero when not driving |
| dout_oe_o | output | 1 | Output-enable for the external bus driver |

## Verification
The hardest case to reach is a write attempt that the select logic blocks. It shows nothing at the ports when it happens, because the output stays disabled either way. The bench therefore fills every word with a known pattern first. It then tries all 31 non-selecting select combinations, each one with both a write and a combined read-and-write request that carry inverted data. Finally it reads all 128 words back and compares them with its own reference array, so any write that slipped through shows up as a changed word.

// File: rtl/mram_pkg.sv
package mram_pkg;
  typedef enum logic [1:0] {
    MODE_DESEL   = 2'd0,
    MODE_STANDBY = 2'd1,
    MODE_READ    = 2'd2,
    MODE_WRITE   = 2'd3
  } mram_mode_e;
endpackage

// File: rtl/mram_mode_dec.sv
module mram_mode_dec
  import mram_pkg::*;
#(
  parameter int N_HI = 2,
  parameter int N_LO = 3
) (
  input  logic [N_HI-1:0] sel_hi_i,
  input  logic [N_LO-1:0] sel_lo_i,
  input  logic            rd_n_i,
  input  logic            wr_n_i,
  output logic            sel_o,
  output mram_mode_e      mode_o
);
  // The device is active only when every select agrees.
  always_comb begin
    sel_o = (&sel_hi_i) & ~(|sel_lo_i);
    if (!sel_o)       mode_o = MODE_DESEL;
    else if (!wr_n_i) mode_o = MODE_WRITE;   // write wins over read
    else if (!rd_n_i) mode_o = MODE_READ;
    else              mode_o = MODE_STANDBY;
  end

  // R2: the mode never leaves deselect unless all selects are active
  always_comb begin
    a_r2_sel_rule: assert ((mode_o == MODE_DESEL) || ((&sel_hi_i) && !(|sel_lo_i)))
      else $error("select rule violated");
  end
endmodule

// File: rtl/mram_array.sv
module mram_array #(
  parameter int ADDR_W   = 7,
  parameter int DATA_W   = 8,
  parameter int COL_BITS = 3
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int ROW_BITS = ADDR_W - COL_BITS;
  localparam int ROWS     = 1 << ROW_BITS;
  localparam int COLS     = 1 << COL_BITS;

  logic [ROW_BITS-1:0] row_sel;
  logic [COL_BITS-1:0] col_sel;
  logic [DATA_W-1:0]   row_rd [ROWS];

  assign row_sel = addr_i[ADDR_W-1:COL_BITS];
  assign col_sel = addr_i[COL_BITS-1:0];

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    logic [DATA_W-1:0] cells [COLS];
    logic              row_we;
    assign row_we = we_i && (row_sel == ROW_BITS'(r));
    always_ff @(posedge clk_i) begin
      if (row_we) cells[col_sel] <= wdata_i;
    end
    assign row_rd[r] = cells[col_sel];
  end

  assign rdata_o = row_rd[row_sel];
endmodule

// File: rtl/mram_rd_stage.sv
module mram_rd_stage #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_n_i,
  input  logic              rd_en_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic [DATA_W-1:0] dout_o,
  output logic              dout_oe_o
);
  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      dout_o    <= '0;
      dout_oe_o <= 1'b0;
    end else begin
      dout_oe_o <= rd_en_i;
      dout_o    <= rd_en_i ? rdata_i : '0;
    end
  end

  a_r7_quiet_when_off: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    !dout_oe_o |-> (dout_o == '0));
  a_r8_data_follows: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    rd_en_i |=> (dout_o == $past(rdata_i)));
endmodule

// File: rtl/mram_top.sv
module mram_top
  import mram_pkg::*;
#(
  parameter int ADDR_W   = 7,
  parameter int DATA_W   = 8,
  parameter int COL_BITS = 3,
  parameter int N_HI     = 2,
  parameter int N_LO     = 3
) (
  input  logic              clk_i,
  input  logic              rst_n_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rd_n_i,
  input  logic              wr_n_i,
  input  logic [N_HI-1:0]   sel_hi_i,
  input  logic [N_LO-1:0]   sel_lo_i,
  input  logic [DATA_W-1:0] din_i,
  output logic [DATA_W-1:0] dout_o,
  output logic              dout_oe_o
);
  logic              sel;
  mram_mode_e        mode;
  logic [DATA_W-1:0] rdata;

  mram_mode_dec #(.N_HI(N_HI), .N_LO(N_LO)) i_dec (
    .sel_hi_i(sel_hi_i), .sel_lo_i(sel_lo_i),
    .rd_n_i(rd_n_i), .wr_n_i(wr_n_i),
    .sel_o(sel), .mode_o(mode)
  );

  mram_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .COL_BITS(COL_BITS)) i_arr (
    .clk_i(clk_i), .we_i(mode == MODE_WRITE),
    .addr_i(addr_i), .wdata_i(din_i), .rdata_o(rdata)
  );

  mram_rd_stage #(.DATA_W(DATA_W)) i_rd (
    .clk_i(clk_i), .rst_n_i(rst_n_i),
    .rd_en_i(mode == MODE_READ), .rdata_i(rdata),
    .dout_o(dout_o), .dout_oe_o(dout_oe_o)
  );

  a_r3_desel_quiet: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    !sel |=> !dout_oe_o);
  a_r4_read_drives: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (sel && !rd_n_i && wr_n_i) |=> dout_oe_o);
  a_r5_write_quiet: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (sel && !wr_n_i) |=> !dout_oe_o);
  a_r6_standby_quiet: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (sel && rd_n_i && wr_n_i) |=> !dout_oe_o);
endmodule

// File: tb/test_mram_top.sv
module test_mram_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [6:0] addr;
  logic       rd_n, wr_n;
  logic [4:0] sel5;
  logic [7:0] din;
  logic [7:0] dout;
  logic       dout_oe;
  int n_chk = 0, n_bad = 0;
  logic [7:0] ref_mem [128];
  bit done = 0;

  localparam logic [4:0] SEL_ON = 5'b00011; // [1:0] active-high, [4:2] active-low

  always #10 clk = ~clk;

  mram_top i_mram_top (
    .clk_i(clk), .rst_n_i(rst_n), .addr_i(addr), .rd_n_i(rd_n), .wr_n_i(wr_n),
    .sel_hi_i(sel5[1:0]), .sel_lo_i(sel5[4:2]), .din_i(din),
    .dout_o(dout), .dout_oe_o(dout_oe)
  );

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 37 + 5) & 255);
  endfunction

  task automatic chk(input string req, input logic [7:0] ed, input logic eoe);
    n_chk++;
    if (dout !== ed || dout_oe !== eoe) begin
      n_bad++;
      $display("FAIL %s: dout=%h oe=%b expected dout=%h oe=%b", req, dout, dout_oe, ed, eoe);
    end
  endtask

  // inputs change mid-cycle; outputs are sampled 5 ns after the edge
  task automatic step(input logic [4:0] s, input logic r, input logic w,
                      input logic [6:0] a, input logic [7:0] d);
    sel5 = s; rd_n = r; wr_n = w; addr = a; din = d;
    @(posedge clk);
    #5;
    if (s == SEL_ON && !w) ref_mem[a] = d;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(20 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: run hung, expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; sel5 = SEL_ON; rd_n = 1'b0; wr_n = 1'b1; addr = '0; din = '0;
    repeat (3) @(posedge clk);
    #5;
    chk("R9 in reset", 8'h00, 1'b0);
    rst_n = 1'b1;
    step(SEL_ON, 1'b1, 1'b1, 7'd0, 8'h00);
    chk("R9 after reset", 8'h00, 1'b0);

    // R1/R5: fill every word
    for (int a = 0; a < 128; a++) begin
      step(SEL_ON, 1'b1, 1'b0, 7'(a), pat(a));
      chk("R5 write quiet", 8'h00, 1'b0);
    end
    // R1/R4/R8: back-to-back reads
    for (int a = 0; a < 128; a++) begin
      step(SEL_ON, 1'b0, 1'b1, 7'(a), 8'h00);
      chk("R4 R8 read sweep", ref_mem[a], 1'b1);
    end

    // R3: blocked writes for every non-selecting combination
    for (int s = 0; s < 32; s++) begin
      if (5'(s) != SEL_ON) begin
        step(5'(s), 1'b1, 1'b0, 7'(s), ~pat(s));
        chk("R3 write blocked", 8'h00, 1'b0);
        step(5'(s), 1'b0, 1'b0, 7'(s + 64), ~pat(s + 64));
        chk("R3 read+write blocked", 8'h00, 1'b0);
      end
    end
    // R2/R3: read attempts under every combination
    for (int s = 0; s < 32; s++) begin
      step(5'(s), 1'b0, 1'b1, 7'(s + 32), 8'h00);
      if (5'(s) == SEL_ON) chk("R2 read selected", ref_mem[s + 32], 1'b1);
      else                 chk("R3 read deselected", 8'h00, 1'b0);
    end

    // R6: standby
    step(SEL_ON, 1'b1, 1'b1, 7'd5, 8'hFF);
    chk("R6 standby", 8'h00, 1'b0);
    step(SEL_ON, 1'b1, 1'b1, 7'd6, 8'hEE);
    chk("R7 standby zero", 8'h00, 1'b0);

    // R3/R6: contents untouched
    for (int a = 0; a < 128; a++) begin
      step(SEL_ON, 1'b0, 1'b1, 7'(a), 8'h00);
      chk("R3 R6 contents kept", ref_mem[a], 1'b1);
    end

    // R5: write with read strobe also low; R10: read right after
    step(SEL_ON, 1'b0, 1'b0, 7'd9, 8'hA5);
    chk("R5 write with rd low", 8'h00, 1'b0);
    step(SEL_ON, 1'b0, 1'b1, 7'd9, 8'h00);
    chk("R10 read after write", 8'hA5, 1'b1);
    step(SEL_ON, 1'b0, 1'b1, 7'd8, 8'h00);
    chk("R1 neighbour intact", ref_mem[8], 1'b1);

    // R3/R4: output drops the cycle after a single select goes inactive
    for (int i = 0; i < 5; i++) begin
      step(SEL_ON, 1'b0, 1'b1, 7'(100 + i), 8'h00);
      chk("R4 read before drop", ref_mem[100 + i], 1'b1);
      step(SEL_ON ^ 5'(1 << i), 1'b0, 1'b1, 7'(100 + i), 8'h00);
      chk("R3 single select drop", 8'h00, 1'b0);
    end
    // R4/R7: releasing the read strobe
    step(SEL_ON, 1'b0, 1'b1, 7'd127, 8'h00);
    chk("R4 last word", ref_mem[127], 1'b1);
    step(SEL_ON, 1'b1, 1'b1, 7'd127, 8'h00);
    chk("R7 strobe release", 8'h00, 1'b0);

    finish_run();
  end
endmodule